// File: doc/BRIEF.md
# Gated I2C Bus Repeater

This block lets a host I2C bus reach a second, downstream I2C segment only when software asks for it. A noisy or sensitive device on the downstream segment stays quiet until the host sets a one-shot arm bit. The next message on the host bus, from its start condition to its stop condition, is then copied onto the downstream lines. The arm bit clears itself at that stop. Any number of bytes to any address may pass in between.

Traffic is carried both ways. The block follows the bit and acknowledge slots of the message, including the read/write bit of the address byte. In every slot where the downstream device is meant to drive data, the block releases the downstream data line and copies the level the downstream device drives back onto the host data line. A 2-bit setting delays the forwarded levels by whole units of system clocks, so that slow-rising downstream lines keep up. While no message is being forwarded, the two downstream outputs rest high, or act as general-purpose outputs when that mode is selected. The synchronised level of the downstream data line is always available for readback.

Top module: `i2c_gated_repeater`

## Requirements
- R1: During and right after reset, both downstream outputs are high, the arm status reads 0 and the host data pull-down is off.
- R2: A one-cycle pulse on `arm_set` raises `armed` at the next clock edge. `armed` stays high through the whole forwarded message.
- R3: While not armed, host traffic, start and stop conditions included, leaves both downstream outputs high (general-purpose mode off).
- R4: Once armed, the block forwards from the next start condition on (data falling while clock high), for any number of bytes. With delay setting 0, each host level reaches the downstream outputs 3 clock edges after it is applied.
- R5: A stop condition (data rising while clock high) inside a forwarded message is itself forwarded. It then clears `armed`, and the next message is not forwarded.
- R6: In the slots where the downstream device drives data, the block keeps `dn_sda_o` high and drives `up_sda_oe` to the inverse of the downstream data level. These slots are the acknowledge slot of a write-direction byte, the address acknowledge, and the data bits of a read, where read is address bit 0 = 1. After a read byte whose acknowledge slot carries 1 from the host (no-acknowledge), the host drives again until the next start.
- R7: When not forwarding and `gpio_en` is 1, `dn_scl_o` and `dn_sda_o` follow `gpio_scl` and `gpio_sda` one clock edge later (delay setting 0).
- R8: `dly_sel` = n adds n*DLY_UNIT clock edges to the forwarding latency. The output must not change before that latency.
- R9: `dn_sda_stat` reports the level of `dn_sda_i` two clock edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_set | input | 1 | One-cycle pulse: arm forwarding of the next message |
| gpio_en | input | 1 | 1: downstream outputs follow the gpio levels when not forwarding |
| gpio_scl | input | 1 | General-purpose level for the downstream clock output |
| gpio_sda | input | 1 | General-purpose level for the downstream data output |
| dly_sel | input | 2 | Forwarding delay in units of DLY_UNIT clocks |
| up_scl_i | input | 1 | Host bus clock line level |
| up_sda_i | input | 1 | Host bus data line level |
| up_sda_oe | output | 1 | 1: pull the host data line low |
| dn_sda_i | input | 1 | Downstream data line level |
| dn_scl_o | output | 1 | Downstream clock drive (1 = release high) |
| dn_sda_o | output | 1 | Downstream data drive (1 = release high) |
| armed | output | 1 | Arm bit status, clears itself after the forwarded stop |
| dn_sda_stat | output | 1 | Synchronised downstream data level for readback |

## Verification
The bench sends a full message while disarmed and checks that nothing reaches the downstream side; a repeater that ignores the arm bit would copy it. It then forwards a write message with slave acknowledges and a read message with slave data and a host no-acknowledge. A design that tracks the slots wrongly would either echo its own pull-down back and lock the bus, or hide the forwarded stop. After each forwarded stop it checks that the arm bit has cleared and that a further message stays blocked. With a non-zero delay, it checks both the cycle just before the expected latency and the cycle of it, which catches a tap taken one unit early.

// File: rtl/i2crep_pkg.sv
`timescale 1ns/1ps
// Shared types and constants of the gated I2C repeater.
package i2crep_pkg;
    // Control states: no forwarding, waiting for a start, copying a message.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FWD   = 2'd2
    } rep_state_e;

    localparam int CNT_W = 4;
    // Index of the acknowledge slot inside a 9-slot byte.
    localparam logic [CNT_W-1:0] ACK_SLOT = 4'd8;
    // Index of the last data bit, the read/write bit in the address byte.
    localparam logic [CNT_W-1:0] RW_SLOT  = 4'd7;
endpackage

// File: rtl/i2crep_sense.sv
`timescale 1ns/1ps
// Line sensing: synchronises the host clock/data and the downstream data
// lines to clk and derives start, stop and clock edge strobes.
// Assumes the lines change far slower than clk (SYNC_STAGES >= 2).
module i2crep_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic dsda_i,
    output logic scl_s,
    output logic sda_s,
    output logic dsda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh, dsda_sh;
    logic scl_p, sda_p;

    // Synchroniser chains, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh  <= '1;
            sda_sh  <= '1;
            dsda_sh <= '1;
        end else begin
            scl_sh  <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh  <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            dsda_sh <= {dsda_sh[SYNC_STAGES-2:0], dsda_i};
        end
    end

    assign scl_s  = scl_sh[SYNC_STAGES-1];
    assign sda_s  = sda_sh[SYNC_STAGES-1];
    assign dsda_s = dsda_sh[SYNC_STAGES-1];

    // One-cycle history of the synchronised host lines for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/i2crep_phase.sv
`timescale 1ns/1ps
// Slot tracker: counts clock rises since the last start, captures the
// read/write bit of the address byte and latches, at each clock fall, which
// side owns the data line in the coming low/high period.
// Assumes start_det, scl_rise and scl_fall are mutually exclusive strobes.
module i2crep_phase
    import i2crep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_s,
    output logic slave_drv
);
    logic [CNT_W-1:0] rise_cnt, phase_q;
    logic first_q, phase_first_q, rd_q, done_q;
    logic rd_data;

    // Rise counting, direction capture and no-acknowledge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || start_det) begin
            rise_cnt <= '0;
            first_q  <= 1'b1;
            rd_q     <= 1'b0;
            done_q   <= 1'b0;
        end else if (scl_rise) begin
            if (rise_cnt == ACK_SLOT) begin
                rise_cnt <= '0;
                first_q  <= 1'b0;
                if (rd_q && !first_q && sda_s) done_q <= 1'b1;
            end else begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            if (first_q && rise_cnt == RW_SLOT) rd_q <= sda_s;
        end
    end

    // Slot latch: the period after a fall belongs to the slot just counted.
    always_ff @(posedge clk) begin
        if (!rst_n || start_det) begin
            phase_q       <= '0;
            phase_first_q <= 1'b1;
        end else if (scl_fall) begin
            phase_q       <= rise_cnt;
            phase_first_q <= first_q;
        end
    end

    assign rd_data   = rd_q & ~phase_first_q;
    assign slave_drv = ~done_q & ((phase_q == ACK_SLOT) ? ~rd_data : rd_data);

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= ACK_SLOT);
endmodule

// File: rtl/i2crep_delay.sv
`timescale 1ns/1ps
// Programmable delay line: the output register follows the input after
// 0..3 units of UNIT clocks, picked by sel. Assumes UNIT >= 1.
module i2crep_delay #(
    parameter int W    = 2,
    parameter int UNIT = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int DEPTH = 3 * UNIT;

    logic [DEPTH-1:0][W-1:0] stage;
    logic [W-1:0] tap;

    // Shift register holding the recent history of din.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= {DEPTH{RST_VAL}};
        else        stage <= {stage[DEPTH-2:0], din};
    end

    // Tap selection by delay unit count.
    always_comb begin
        case (sel)
            2'd0:    tap = din;
            2'd1:    tap = stage[UNIT-1];
            2'd2:    tap = stage[2*UNIT-1];
            default: tap = stage[DEPTH-1];
        endcase
    end

    // Output register driving the downstream lines.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= RST_VAL;
        else        dout <= tap;
    end

    // R8
    tap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> (dout == $past(din)));
endmodule

// File: rtl/i2c_gated_repeater.sv
`timescale 1ns/1ps
// Gated I2C repeater top: one-shot arm bit, forwarding from the next start
// to its stop, drive-back of downstream data into the host bus, a
// programmable output delay and general-purpose use of the outputs when
// idle. Assumes open-drain pads outside: a 0 output pulls the line low.
module i2c_gated_repeater
    import i2crep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_UNIT    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_set,
    input  logic       gpio_en,
    input  logic       gpio_scl,
    input  logic       gpio_sda,
    input  logic [1:0] dly_sel,
    input  logic       up_scl_i,
    input  logic       up_sda_i,
    output logic       up_sda_oe,
    input  logic       dn_sda_i,
    output logic       dn_scl_o,
    output logic       dn_sda_o,
    output logic       armed,
    output logic       dn_sda_stat
);
    rep_state_e state_q, state_d;
    logic scl_s, sda_s, dsda_s, start_det, stop_det, scl_rise, scl_fall;
    logic slave_drv, fwd_now, back_drv, src_scl, src_sda, oe_q;
    logic [1:0] dly_out;

    i2crep_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(up_scl_i), .sda_i(up_sda_i),
        .dsda_i(dn_sda_i), .scl_s(scl_s), .sda_s(sda_s), .dsda_s(dsda_s),
        .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2crep_phase u_phase (
        .clk(clk), .rst_n(rst_n), .start_det(start_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .slave_drv(slave_drv)
    );

    // Next-state logic of the arm/forward control.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (arm_set)   state_d = ST_ARMED;
            ST_ARMED: if (start_det) state_d = ST_FWD;
            ST_FWD:   if (stop_det)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Control state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign fwd_now  = (state_q == ST_FWD) | ((state_q == ST_ARMED) & start_det);
    assign back_drv = (state_q == ST_FWD) & slave_drv;

    // Source levels for the downstream outputs before the delay line.
    always_comb begin
        if (fwd_now) begin
            src_scl = scl_s;
            src_sda = back_drv ? 1'b1 : sda_s;
        end else if (gpio_en) begin
            src_scl = gpio_scl;
            src_sda = gpio_sda;
        end else begin
            src_scl = 1'b1;
            src_sda = 1'b1;
        end
    end

    i2crep_delay #(.W(2), .UNIT(DLY_UNIT), .RST_VAL(2'b11)) u_delay (
        .clk(clk), .rst_n(rst_n), .sel(dly_sel),
        .din({src_scl, src_sda}), .dout(dly_out)
    );

    // Host data pull-down while the downstream device drives a low level.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= back_drv & ~dsda_s;
    end

    assign dn_scl_o    = dly_out[1];
    assign dn_sda_o    = dly_out[0];
    assign up_sda_oe   = oe_q;
    assign armed       = (state_q != ST_IDLE);
    assign dn_sda_stat = dsda_s;

    // R2
    arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !stop_det) |=> armed);
    // R5
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FWD && stop_det) |=> !armed);
    // R6
    oe_needs_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_sda_oe |-> $past(state_q == ST_FWD));
endmodule

// File: tb/test_i2c_gated_repeater.sv
`timescale 1ns/1ps
// Scoreboard bench: message tasks push the expected downstream levels with
// their due cycle; a monitor pops and compares them at that cycle.
module test_i2c_gated_repeater;
    localparam int UNIT = 4;
    localparam int H    = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, arm_set, gpio_en, gpio_scl, gpio_sda;
    logic [1:0] dly_sel;
    logic m_scl, m_sda, slave_sda;
    logic up_sda_oe, dn_scl_o, dn_sda_o, armed, dn_sda_stat;
    logic up_sda_line, dn_sda_line;

    assign up_sda_line = m_sda & ~up_sda_oe;
    assign dn_sda_line = dn_sda_o & slave_sda;

    i2c_gated_repeater #(.SYNC_STAGES(2), .DLY_UNIT(UNIT)) i_i2c_gated_repeater (
        .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .gpio_en(gpio_en),
        .gpio_scl(gpio_scl), .gpio_sda(gpio_sda), .dly_sel(dly_sel),
        .up_scl_i(m_scl), .up_sda_i(up_sda_line), .up_sda_oe(up_sda_oe),
        .dn_sda_i(dn_sda_line), .dn_scl_o(dn_scl_o), .dn_sda_o(dn_sda_o),
        .armed(armed), .dn_sda_stat(dn_sda_stat)
    );

    typedef struct {
        int   due;
        logic scl;
        logic sda;
        logic dc;
        int   tag;
    } item_t;

    item_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   lat = 3;
    int   cur_tag = 3;
    logic last_scl = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string tname(input int t);
        case (t)
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Monitor: compares popped expectations, and the level one cycle early.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            if (cyc == q[0].due - 1 && q[0].scl != last_scl)
                chk(dn_scl_o == last_scl, tname(q[0].tag), int'(dn_scl_o), int'(last_scl));
            if (cyc == q[0].due) begin
                chk(dn_scl_o == q[0].scl, tname(q[0].tag), int'(dn_scl_o), int'(q[0].scl));
                if (!q[0].dc)
                    chk(dn_sda_o == q[0].sda, tname(q[0].tag), int'(dn_sda_o), int'(q[0].sda));
                last_scl = q[0].scl;
                void'(q.pop_front());
            end
        end
    end

    // Driver: applies host levels and pushes the expected downstream levels.
    task automatic step(input logic s, input logic d, input bit fwd, input bit dc);
        item_t it;
        @(negedge clk);
        m_scl = s;
        m_sda = d;
        it.due = cyc + lat;
        it.scl = fwd ? s : 1'b1;
        it.sda = fwd ? d : 1'b1;
        it.dc  = fwd ? dc : 1'b0;
        it.tag = cur_tag;
        q.push_back(it);
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, input bit fwd, input bit is_slave, input logic sv);
        step(1'b0, m_sda, fwd, 1'b1);
        slave_sda = is_slave ? sv : 1'b1;
        step(1'b0, is_slave ? 1'b1 : b, fwd, 1'b0);
        if (is_slave && fwd) begin
            chk(up_sda_oe == !sv, "R6", int'(up_sda_oe), int'(!sv));
            chk(up_sda_line == sv, "R6", int'(up_sda_line), int'(sv));
            chk(dn_sda_o == 1'b1, "R6", int'(dn_sda_o), 1);
        end
        step(1'b1, is_slave ? 1'b1 : b, fwd, 1'b0);
    endtask

    task automatic put_byte(input logic [7:0] v, input bit fwd, input bit by_slave);
        for (int i = 7; i >= 0; i--) put_bit(v[i], fwd, by_slave, v[i]);
    endtask

    task automatic start_msg(input bit fwd);
        step(1'b1, 1'b1, fwd, 1'b0);
        step(1'b1, 1'b0, fwd, 1'b0);
    endtask

    task automatic stop_msg(input bit fwd);
        step(1'b0, m_sda, fwd, 1'b1);
        slave_sda = 1'b1;
        step(1'b0, 1'b0, fwd, 1'b0);
        step(1'b1, 1'b0, fwd, 1'b0);
        step(1'b1, 1'b1, fwd, 1'b0);
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm_set = 1'b1;
        @(negedge clk) arm_set = 1'b0;
        chk(armed == 1'b1, "R2", int'(armed), 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; arm_set = 1'b0; gpio_en = 1'b0; gpio_scl = 1'b0; gpio_sda = 1'b0;
        dly_sel = 2'd0; m_scl = 1'b1; m_sda = 1'b1; slave_sda = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(dn_scl_o == 1'b1, "R1", int'(dn_scl_o), 1);
        chk(dn_sda_o == 1'b1, "R1", int'(dn_sda_o), 1);
        chk(armed == 1'b0, "R1", int'(armed), 0);
        chk(up_sda_oe == 1'b0, "R1", int'(up_sda_oe), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dn_scl_o == 1'b1 && dn_sda_o == 1'b1, "R1", int'({dn_scl_o, dn_sda_o}), 3);

        // R9: readback of the downstream data level
        slave_sda = 1'b0;
        @(negedge clk);
        chk(dn_sda_stat == 1'b1, "R9", int'(dn_sda_stat), 1);
        @(negedge clk);
        chk(dn_sda_stat == 1'b0, "R9", int'(dn_sda_stat), 0);
        slave_sda = 1'b1;
        repeat (3) @(negedge clk);

        // R7: general-purpose outputs
        gpio_en = 1'b1; gpio_scl = 1'b0; gpio_sda = 1'b1;
        @(negedge clk);
        chk(dn_scl_o == 1'b0 && dn_sda_o == 1'b1, "R7", int'({dn_scl_o, dn_sda_o}), 1);
        gpio_scl = 1'b1; gpio_sda = 1'b0;
        @(negedge clk);
        chk(dn_scl_o == 1'b1 && dn_sda_o == 1'b0, "R7", int'({dn_scl_o, dn_sda_o}), 2);
        gpio_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(dn_scl_o == 1'b1 && dn_sda_o == 1'b1, "R7", int'({dn_scl_o, dn_sda_o}), 3);

        // R3: a whole message while disarmed stays off the downstream lines
        cur_tag = 3;
        start_msg(1'b0);
        put_byte(8'hA4, 1'b0, 1'b0);
        put_bit(1'b0, 1'b0, 1'b0, 1'b0);
        stop_msg(1'b0);
        chk(armed == 1'b0, "R3", int'(armed), 0);
        repeat (lat + 2) @(negedge clk);

        // R2 and R4: armed write message with slave acknowledges
        pulse_arm();
        repeat (5) @(negedge clk);
        chk(armed == 1'b1, "R2", int'(armed), 1);
        cur_tag = 4;
        start_msg(1'b1);
        put_byte(8'hA0, 1'b1, 1'b0);
        put_bit(1'b0, 1'b1, 1'b1, 1'b0);
        put_byte(8'h3C, 1'b1, 1'b0);
        put_bit(1'b0, 1'b1, 1'b1, 1'b0);
        chk(armed == 1'b1, "R2", int'(armed), 1);
        stop_msg(1'b1);
        chk(armed == 1'b0, "R5", int'(armed), 0);
        repeat (lat + 2) @(negedge clk);

        // R5: the message after the forwarded stop is blocked again
        cur_tag = 5;
        start_msg(1'b0);
        put_byte(8'h5A, 1'b0, 1'b0);
        put_bit(1'b0, 1'b0, 1'b0, 1'b0);
        stop_msg(1'b0);
        chk(armed == 1'b0, "R5", int'(armed), 0);
        repeat (lat + 2) @(negedge clk);

        // R8 and R6: delayed read message, slave data, host no-acknowledge
        dly_sel = 2'd2;
        lat = 3 + 2 * UNIT;
        cur_tag = 8;
        repeat (lat + 2) @(negedge clk);
        pulse_arm();
        start_msg(1'b1);
        put_byte(8'hA1, 1'b1, 1'b0);
        put_bit(1'b0, 1'b1, 1'b1, 1'b0);
        put_byte(8'h96, 1'b1, 1'b1);
        put_bit(1'b1, 1'b1, 1'b0, 1'b1);
        chk(up_sda_oe == 1'b0, "R6", int'(up_sda_oe), 0);
        stop_msg(1'b1);
        chk(armed == 1'b0, "R5", int'(armed), 0);
        repeat (lat + 4) @(negedge clk);
        chk(q.size() == 0, "R8", q.size(), 0);

        finish_run();
    end
endmodule